// File: doc/BRIEF.md
# CAN Receive FIFO and Flag Controller

This block sits between a CAN frame receiver and the CPU on the receive path. Each frame that the protocol engine accepts arrives as a one-cycle strobe with its payload. The block keeps accepted frames in a small first-in first-out store and moves the oldest one into a foreground buffer that the CPU reads. A receive-full flag reports that the foreground buffer holds an unread message. While that flag is set, the buffer stays frozen. The CPU releases the buffer by writing 1 to the flag, and the next stored frame then moves forward. When a frame arrives and every FIFO entry is occupied, the frame is dropped and a sticky overrun flag is raised.

Two CPU-visible registers are selected by a one-bit address. Writes are single-cycle strobes and reads are combinational. Address 0 is the flag register. Bit 0 is receive-full and bit 1 is overrun; both are cleared by writing 1. Bits [3:2] give the transmitter error-state code and bits [5:4] give the receiver error-state code, and both fields are read-only. Address 1 is the interrupt-enable register. Bit 0 enables the receive interrupt and bit 1 enables the overrun interrupt. Bits [3:2] enable transmitter state-change reporting and bits [5:4] enable receiver state-change reporting. The state codes are 0 for OK, 1 for warning, 2 for error-passive and 3 for bus-off.

The frame input has no back-pressure. The receiver cannot be stalled, so the block has no ready signal. A frame that arrives while all storage is full is counted as lost and reported through the overrun flag. A frame arriving in the same cycle that the FIFO moves an entry into the foreground buffer is still accepted.

Top module: `can_rx_fifo_ctl`

## Requirements
- R1: After reset, receive-full, overrun, both interrupt outputs and every interrupt-enable bit are 0.
- R2: A frame strobed while storage is empty appears on the foreground output, with receive-full set, two clock edges after the strobe.
- R3: While receive-full is set, the foreground data does not change. Frames reach the foreground strictly in arrival order.
- R4: Writing address 0 with bit 0 at 1 clears receive-full on the next edge, and the next stored frame is loaded on the edge after that. Writing 0 to bit 0 has no effect.
- R5: A frame arriving while DEPTH (4) entries are stored and no entry is moving forward is dropped and sets overrun. The stored frames are left unchanged.
- R6: Overrun stays set until a write to address 0 with bit 1 at 1 clears it. Writing 0 to bit 1 has no effect.
- R7: When a set and a write-1 clear of the same flag fall in the same cycle, the flag ends up set.
- R8: The receive interrupt equals receive-full AND enable bit 0. The error interrupt equals overrun AND enable bit 1.
- R9: While init request and init acknowledge are both 1, enable bits [1:0] are forced to 0. Bits [5:2] keep their value.
- R10: A write to the interrupt-enable register takes effect only while init request and init acknowledge are both 0.
- R11: Flag register bits [3:2] show the transmitter code one cycle late. Bits [5:4] show the receiver code one cycle late, with two exceptions. While the transmitter code is 3 (bus-off), they read 3. After the transmitter leaves bus-off, they read 0 (OK) until the receiver input code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe marking an accepted frame |
| frm_data | input | DATA_W | Payload of the accepted frame |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 1 | Register select: 0 selects flags, 1 selects interrupt enables |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data of the selected register |
| init_req | input | 1 | Initialization-mode request |
| init_ack | input | 1 | Initialization-mode acknowledge |
| tx_state | input | 2 | Transmitter error-state code |
| rx_state | input | 2 | Receiver error-state code |
| fg_data | output | DATA_W | Foreground buffer contents |
| rx_full | output | 1 | Receive-full flag |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error (overrun) interrupt request |

## Verification
The FIFO is driven with bursts of zero to six frames while the foreground buffer is never released. These bursts separate the empty case, the partly filled case, the exactly full case (one frame in the foreground plus four stored) and the overflow case. Each burst uses a distinct payload base, so the drained sequence shows both the arrival order and that a dropped frame left no trace in storage. Interrupt enables are swept over all four combinations while both flags are set, which separates the two interrupt outputs. All four combinations of init request and acknowledge are applied against a write of zeros over an all-ones register, which separates write gating from forced clearing. A set and a clear issued in the same cycle, and a transmitter leaving bus-off while the receiver code is held steady, cover the remaining ordering cases.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  localparam int REG_W = 8;

  localparam logic ADDR_FLAG = 1'b0;
  localparam logic ADDR_IER  = 1'b1;

  // flag register layout
  localparam int FL_RXF = 0;
  localparam int FL_OVR = 1;
  localparam int FL_TX  = 2;
  localparam int FL_RX  = 4;

  // enable register layout
  localparam int EN_RX  = 0;
  localparam int EN_OVR = 1;
  localparam int IER_W  = 6;

  localparam logic [1:0] ST_OK     = 2'd0;
  localparam logic [1:0] ST_BUSOFF = 2'd3;
endpackage

// File: rtl/can_rxf_store.sv
module can_rxf_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              clr_full_i,
  output logic [DATA_W-1:0] fg_data_o,
  output logic              full_flag_o,
  output logic              drop_o,
  output logic              store_full_o,
  output logic              pop_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_q;
  logic [DATA_W-1:0] fg_q;
  logic              pop, accept, drop, at_cap;

  assign at_cap = (cnt_q == CNT_MAX);
  assign pop    = !full_q && (cnt_q != '0);
  assign drop   = push_i && at_cap && !pop;
  assign accept = push_i && !drop;

  // storage entries, one register row per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accept && (wptr_q == PTR_W'(i)))
        mem_q[i] <= push_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (accept)
        wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + PTR_W'(1);
      if (pop)
        rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + PTR_W'(1);
      if (accept && !pop)
        cnt_q <= cnt_q + CNT_W'(1);
      else if (pop && !accept)
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // foreground buffer: loads only while the full flag is clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      fg_q   <= '0;
    end else begin
      if (pop) begin
        fg_q   <= mem_q[rptr_q];
        full_q <= 1'b1;
      end else if (clr_full_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign fg_data_o    = fg_q;
  assign full_flag_o  = full_q;
  assign drop_o       = drop;
  assign store_full_o = at_cap;
  assign pop_o        = pop;
endmodule

// File: rtl/can_rxf_state.sv
module can_rxf_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tx_i,
  input  logic [1:0] rx_i,
  output logic [1:0] tx_o,
  output logic [1:0] rx_o
);
  import can_rxf_pkg::*;

  logic [1:0] tx_q, rx_q, snap_q;
  logic       hold_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q      <= ST_OK;
      rx_q      <= ST_OK;
      snap_q    <= ST_OK;
      hold_ok_q <= 1'b0;
    end else begin
      tx_q <= tx_i;
      if (tx_i == ST_BUSOFF) begin
        rx_q      <= ST_BUSOFF;
        hold_ok_q <= 1'b0;
      end else if (tx_q == ST_BUSOFF) begin
        rx_q      <= ST_OK;
        snap_q    <= rx_i;
        hold_ok_q <= 1'b1;
      end else if (hold_ok_q && (rx_i == snap_q)) begin
        rx_q <= ST_OK;
      end else begin
        rx_q      <= rx_i;
        hold_ok_q <= 1'b0;
      end
    end
  end

  assign tx_o = tx_q;
  assign rx_o = rx_q;
endmodule

// File: rtl/can_rxf_regs.sv
module can_rxf_regs (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic                           addr_i,
  input  logic [can_rxf_pkg::REG_W-1:0]  wdata_i,
  input  logic                           init_req_i,
  input  logic                           init_ack_i,
  input  logic                           ovr_set_i,
  input  logic                           rx_full_i,
  input  logic [1:0]                     tx_code_i,
  input  logic [1:0]                     rx_code_i,
  output logic [can_rxf_pkg::IER_W-1:0]  ier_o,
  output logic                           ovr_o,
  output logic                           clr_rxf_o,
  output logic [can_rxf_pkg::REG_W-1:0]  rdata_o
);
  import can_rxf_pkg::*;

  logic [IER_W-1:0] ier_q;
  logic             ovr_q;
  logic             in_init, wr_open, flag_wr, ier_wr;

  assign in_init = init_req_i && init_ack_i;
  assign wr_open = !init_req_i && !init_ack_i;
  assign flag_wr = wr_i && (addr_i == ADDR_FLAG);
  assign ier_wr  = wr_i && (addr_i == ADDR_IER) && wr_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
    end else if (ier_wr) begin
      ier_q <= wdata_i[IER_W-1:0];
    end else if (in_init) begin
      ier_q[EN_OVR:EN_RX] <= 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovr_q <= 1'b0;
    else if (ovr_set_i)
      ovr_q <= 1'b1;
    else if (flag_wr && wdata_i[FL_OVR])
      ovr_q <= 1'b0;
  end

  assign clr_rxf_o = flag_wr && wdata_i[FL_RXF];

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_FLAG) begin
      rdata_o[FL_RXF]         = rx_full_i;
      rdata_o[FL_OVR]         = ovr_q;
      rdata_o[FL_TX+1:FL_TX]  = tx_code_i;
      rdata_o[FL_RX+1:FL_RX]  = rx_code_i;
    end else begin
      rdata_o[IER_W-1:0] = ier_q;
    end
  end

  assign ier_o = ier_q;
  assign ovr_o = ovr_q;
endmodule

// File: rtl/can_rx_fifo_ctl.sv
module can_rx_fifo_ctl #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              cpu_wr,
  input  logic              cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              init_req,
  input  logic              init_ack,
  input  logic [1:0]        tx_state,
  input  logic [1:0]        rx_state,
  output logic [DATA_W-1:0] fg_data,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              err_irq
);
  import can_rxf_pkg::*;

  logic             clr_rxf, drop, fifo_full, fifo_pop, ovr_q;
  logic [IER_W-1:0] ier;
  logic [1:0]       tx_code, rx_code;

  can_rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (frm_valid),
    .push_data_i  (frm_data),
    .clr_full_i   (clr_rxf),
    .fg_data_o    (fg_data),
    .full_flag_o  (rx_full),
    .drop_o       (drop),
    .store_full_o (fifo_full),
    .pop_o        (fifo_pop)
  );

  can_rxf_state u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_i  (tx_state),
    .rx_i  (rx_state),
    .tx_o  (tx_code),
    .rx_o  (rx_code)
  );

  can_rxf_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (cpu_wr),
    .addr_i     (cpu_addr),
    .wdata_i    (cpu_wdata),
    .init_req_i (init_req),
    .init_ack_i (init_ack),
    .ovr_set_i  (drop),
    .rx_full_i  (rx_full),
    .tx_code_i  (tx_code),
    .rx_code_i  (rx_code),
    .ier_o      (ier),
    .ovr_o      (ovr_q),
    .clr_rxf_o  (clr_rxf),
    .rdata_o    (cpu_rdata)
  );

  assign rx_irq  = rx_full && ier[EN_RX];
  assign err_irq = ovr_q && ier[EN_OVR];
endmodule

// File: rtl/can_rxf_chk.sv
module can_rxf_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic              cpu_wr,
  input logic              cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              init_req,
  input logic              init_ack,
  input logic              rx_full,
  input logic              ovr_q,
  input logic              fifo_full,
  input logic              fifo_pop,
  input logic [DATA_W-1:0] fg_data,
  input logic              rx_irq,
  input logic              err_irq
);
  logic clr_rxf_w, clr_ovr_w;
  assign clr_rxf_w = cpu_wr && !cpu_addr && cpu_wdata[0];
  assign clr_ovr_w = cpu_wr && !cpu_addr && cpu_wdata[1];

  p_hold_fg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !clr_rxf_w |=> rx_full && $stable(fg_data));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && clr_rxf_w |=> !rx_full);

  p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && fifo_full && !fifo_pop |=> ovr_q);

  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !clr_ovr_w |=> ovr_q);

  p_rx_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);

  p_err_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ovr_q);

  p_init_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_req && init_ack |=> !rx_irq && !err_irq);
endmodule

bind can_rx_fifo_ctl can_rxf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .cpu_wr    (cpu_wr),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .init_req  (init_req),
  .init_ack  (init_ack),
  .rx_full   (rx_full),
  .ovr_q     (ovr_q),
  .fifo_full (fifo_full),
  .fifo_pop  (fifo_pop),
  .fg_data   (fg_data),
  .rx_irq    (rx_irq),
  .err_irq   (err_irq)
);

// File: tb/sim_can_rx_fifo_ctl.sv
module sim_can_rx_fifo_ctl;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frm_valid = 1'b0;
  logic [DATA_W-1:0] frm_data = '0;
  logic              cpu_wr = 1'b0;
  logic              cpu_addr = 1'b0;
  logic [7:0]        cpu_wdata = '0;
  logic [7:0]        cpu_rdata;
  logic              init_req = 1'b0;
  logic              init_ack = 1'b0;
  logic [1:0]        tx_state = 2'd0;
  logic [1:0]        rx_state = 2'd0;
  logic [DATA_W-1:0] fg_data;
  logic              rx_full, rx_irq, err_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  can_rx_fifo_ctl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .init_req(init_req), .init_ack(init_ack),
    .tx_state(tx_state), .rx_state(rx_state), .fg_data(fg_data),
    .rx_full(rx_full), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [DATA_W-1:0] d);
    frm_valid = 1'b1;
    frm_data  = d;
    tick();
    frm_valid = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    tick();
    cpu_wr = 1'b0; cpu_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    cpu_addr = a;
    #1;
    v = cpu_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]        v;
    logic [DATA_W-1:0] base;
    int                kept;

    repeat (3) tick();
    // R1: reset values
    chk(rx_full, 0, "R1 rx_full");
    chk(rx_irq, 0, "R1 rx_irq");
    chk(err_irq, 0, "R1 err_irq");
    rd(1'b0, v); chk(v[1:0], 0, "R1 flags");
    rd(1'b1, v); chk(v, 0, "R1 enables");
    rst_n = 1'b1;
    tick();

    // burst sweep: 0..6 frames with the foreground never released
    for (int n = 0; n <= 6; n++) begin
      base = DATA_W'(n * 16'h0100 + 16'h0011);
      for (int k = 0; k < n; k++) send(base + DATA_W'(k));
      tick(); tick();
      chk(rx_full, (n > 0), "R2 full after burst");
      if (n > 0) chk(fg_data, base, "R2 first frame in foreground");
      rd(1'b0, v); chk(v[1], (n > DEPTH + 1), "R5 overrun on burst");
      if (n == 6) begin
        for (int e = 0; e < 4; e++) begin
          wr(1'b1, 8'(e));
          chk(rx_irq, e & 1, "R8 rx_irq");
          chk(err_irq, (e >> 1) & 1, "R8 err_irq");
        end
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);
        tick();
        chk(rx_full, 1, "R4 zero write keeps full");
        rd(1'b0, v); chk(v[1], 1, "R6 zero write keeps overrun");
        chk(fg_data, base, "R3 foreground unchanged");
      end
      kept = (n > DEPTH + 1) ? DEPTH + 1 : n;
      for (int j = 0; j < kept; j++) begin
        chk(fg_data, base + DATA_W'(j), "R3 order");
        wr(1'b0, 8'h01);
        chk(rx_full, 0, "R4 clear");
        tick();
      end
      chk(rx_full, 0, "R4 drained");
      if (n > DEPTH + 1) begin
        wr(1'b0, 8'h02);
        rd(1'b0, v); chk(v[1], 0, "R6 overrun cleared");
      end
    end

    // R7: load and clear of receive-full in the same cycle
    send(16'hBEEF);
    wr(1'b0, 8'h01);
    chk(rx_full, 1, "R7 set beats clear rxf");
    chk(fg_data, 16'hBEEF, "R7 loaded data");
    wr(1'b0, 8'h01);
    tick();
    // R7: overrun set and clear in the same cycle
    for (int k = 0; k < DEPTH + 1; k++) send(16'h0A00 + DATA_W'(k));
    tick();
    frm_valid = 1'b1; frm_data = 16'hDEAD;
    cpu_wr = 1'b1; cpu_addr = 1'b0; cpu_wdata = 8'h02;
    tick();
    frm_valid = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
    rd(1'b0, v); chk(v[1], 1, "R7 set beats clear overrun");
    for (int j = 0; j < DEPTH + 1; j++) begin
      chk(fg_data, 16'h0A00 + DATA_W'(j), "R5 stored frames intact");
      wr(1'b0, 8'h01);
      tick();
    end
    wr(1'b0, 8'h02);

    // R9 / R10: init request/acknowledge combinations
    for (int c = 0; c < 4; c++) begin
      init_req = 1'b0; init_ack = 1'b0;
      wr(1'b1, 8'h3F);
      init_req = c[1]; init_ack = c[0];
      tick();
      wr(1'b1, 8'h00);
      tick();
      rd(1'b1, v);
      if (c == 0)      chk(v, 8'h00, "R10 write when open");
      else if (c == 3) chk(v, 8'h3C, "R9 init clears low enables");
      else             chk(v, 8'h3F, "R10 write blocked");
    end
    init_req = 1'b0; init_ack = 1'b0;

    // R11: state codes
    tx_state = 2'd1; rx_state = 2'd2;
    tick();
    rd(1'b0, v);
    chk(v[3:2], 1, "R11 tx code");
    chk(v[5:4], 2, "R11 rx code");
    tx_state = 2'd3;
    tick();
    rd(1'b0, v); chk(v[5:4], 3, "R11 rx during bus-off");
    tx_state = 2'd0;
    tick();
    rd(1'b0, v); chk(v[5:4], 0, "R11 rx OK on bus-off exit");
    tick(); tick();
    rd(1'b0, v); chk(v[5:4], 0, "R11 rx stays OK");
    rx_state = 2'd1;
    tick();
    rd(1'b0, v); chk(v[5:4], 1, "R11 rx follows new code");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule